// File: doc/BRIEF.md
# Temperature-Adaptive Bank Timing Guard

This block guards the command spacing of a single DRAM bank. It tells a command scheduler which of the four bank commands (activate, read, write, precharge) it may issue in the current cycle. The spacing it enforces is not fixed. It keeps four timing sets, one for each temperature bin, and uses the set that matches the latest temperature reading. Cooler bins use shorter intervals because the cells hold more charge. The hottest bin uses the standard worst-case values, and the block falls back to that set whenever the reading or the refresh setting cannot be trusted.

The scheduler drives its request lines and looks at the matching allowed flags. A command counts as issued in any cycle where its request and its allowed flag are both high. The block measures the time since each triggering command. It compares those elapsed times with the currently active set every cycle, so a change of set also applies to intervals that are already running. A move to a slower set takes effect at once. A move to a faster set needs a run of consecutive matching readings, and it waits until the bank is closed and its precharge has completed.

Top module: `dram_adaptive_timing`

## Requirements
- R1: After reset the active set index is 3 (the worst case), the bank is closed, actOk is 1, and rdOk, wrOk and preOk are 0.
- R2: Set index s (0 = coolest bin, 3 = hottest) holds rcd/ras/wr/rp values computed as follows. The worst values are 11/28/12/11. The coolest value is ceil(worst×(100−cut)/100), with cuts of 17/37/54/35 percent. Set s is cool + ceil((worst−cool)×s/3). This gives 10/18/6/8 for set 0, 11/22/8/9 for set 1, 11/25/10/10 for set 2 and 11/28/12/11 for set 3.
- R3: Read and write are allowed only while a row is open. They become allowed exactly rcd cycles after the clock edge that issued the activate. A precharge closes the row and drops rdOk, wrOk and preOk in the next cycle.
- R4: Precharge is allowed only while a row is open, at least ras cycles after the activate, and at least BURST_LEN (4) + wr cycles after the most recent write.
- R5: Activate is allowed only while the bank is closed and at least rp cycles after the precharge. Issuing an activate drops actOk in the next cycle.
- R6: tempC is an unsigned reading in degrees C. A reading of 55 or below maps to bin 0, 56 to 65 maps to bin 1, 66 to 75 maps to bin 2, and anything higher maps to bin 3. A sample with tempOk = 0 maps to bin 3.
- R7: A sample whose bin is above the active set replaces the active set at the same clock edge that takes the sample.
- R8: A move to a lower set needs HYST (3) consecutive strobed samples that all map to the same lower bin. A sample at the active set or at a different lower bin restarts the count. The change commits on the next edge with no sample where the bank is closed and rp is satisfied, which is one edge after the last sample when the bank is already idle.
- R9: A nonzero refreshCode (0 means the standard 64 ms interval) forces set 3 from the next edge and holds off every lowering for as long as it stays nonzero.
- R10: Intervals are always checked against the active set. A slower set taken in the middle of an interval stretches that interval to the slower value, measured from the original command.
- R11: Only one command is issued per cycle. When several allowed requests arrive together, activate has priority over read, read over write, and write over precharge, and the requests that lose have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tempStb | input | 1 | A new temperature sample is present this cycle |
| tempOk | input | 1 | The sample is valid |
| tempC | input | 8 | Temperature in degrees C |
| refreshCode | input | 2 | Refresh interval code; 0 is the standard interval |
| actReq | input | 1 | Activate request |
| rdReq | input | 1 | Read request |
| wrReq | input | 1 | Write request |
| preReq | input | 1 | Precharge request |
| actOk | output | 1 | Activate allowed this cycle |
| rdOk | output | 1 | Read allowed this cycle |
| wrOk | output | 1 | Write allowed this cycle |
| preOk | output | 1 | Precharge allowed this cycle |
| setIdx | output | 2 | Index of the timing set in use |

## Verification
The hardest case to reach is a switch of set that lands inside a running interval. The stimulus first brings the bank down to the fastest set, issues an activate, and two cycles later presents an over-range reading. The bench then finds the first cycle in which read and precharge are allowed and checks that both match the slow set, counted from the original activate. A second hard case is a lowering that is held back by an open row. To reach it, the bench feeds qualifying samples while a row is open and then confirms that the set changes only once the precharge interval has run out.

// File: rtl/dat_pkg.sv
package dat_pkg;
  localparam int CNT_W = 6;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t rcd;
    cnt_t ras;
    cnt_t wr;
    cnt_t rp;
  } timing_t;

  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
  } cmd_t;

  // Interval for one bin: the coolest value is the worst value scaled down and
  // rounded up, and the bins in between are interpolated upward (also rounded up).
  function automatic cnt_t scaleTiming(int worst, int cutPct, int bin, int nBins);
    int cool;
    int span;
    cool = (worst * (100 - cutPct) + 99) / 100;
    span = worst - cool;
    return cnt_t'(cool + (span * bin + nBins - 2) / (nBins - 1));
  endfunction
endpackage

// File: rtl/dat_table.sv
module dat_table
  import dat_pkg::*;
#(
  parameter int NSETS     = 4,
  parameter int SET_W     = 2,
  parameter int RCD_WORST = 11,
  parameter int RAS_WORST = 28,
  parameter int WR_WORST  = 12,
  parameter int RP_WORST  = 11,
  parameter int RCD_CUT   = 17,
  parameter int RAS_CUT   = 37,
  parameter int WR_CUT    = 54,
  parameter int RP_CUT    = 35
) (
  input  logic [SET_W-1:0] setIdx,
  output timing_t          cur
);
  timing_t tbl [NSETS];

  generate
    for (genvar b = 0; b < NSETS; b++) begin : g_set
      assign tbl[b] = '{rcd: scaleTiming(RCD_WORST, RCD_CUT, b, NSETS),
                        ras: scaleTiming(RAS_WORST, RAS_CUT, b, NSETS),
                        wr:  scaleTiming(WR_WORST,  WR_CUT,  b, NSETS),
                        rp:  scaleTiming(RP_WORST,  RP_CUT,  b, NSETS)};
    end
  endgenerate

  assign cur = tbl[setIdx];
endmodule

// File: rtl/dat_ctrl.sv
module dat_ctrl
  import dat_pkg::*;
#(
  parameter int NSETS    = 4,
  parameter int SET_W    = 2,
  parameter int TEMP_W   = 8,
  parameter int REF_W    = 2,
  parameter int BIN_BASE = 55,
  parameter int BIN_STEP = 10,
  parameter int HYST     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tempStb,
  input  logic              tempOk,
  input  logic [TEMP_W-1:0] tempC,
  input  logic [REF_W-1:0]  refreshCode,
  input  logic              actReq,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic              preReq,
  input  cmd_t              okVec,
  input  logic              bankIdle,
  output cmd_t              issue,
  output logic [SET_W-1:0]  activeSet
);
  localparam int HYST_W = $clog2(HYST + 1);
  localparam logic [SET_W-1:0] WORST = SET_W'(NSETS - 1);
  localparam logic [HYST_W-1:0] HYST_FULL = HYST_W'(HYST);

  logic [SET_W-1:0]  sampleBin;
  logic [SET_W-1:0]  candSet;
  logic [HYST_W-1:0] streak;

  // Bin of the current reading; invalid or over-range readings land on the worst set.
  always_comb begin
    sampleBin = WORST;
    if (tempOk) begin
      for (int b = NSETS - 2; b >= 0; b--) begin
        if (int'(tempC) <= BIN_BASE + b * BIN_STEP) sampleBin = SET_W'(b);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeSet <= WORST;
      candSet   <= WORST;
      streak    <= '0;
    end else if (refreshCode != '0) begin
      activeSet <= WORST;
      streak    <= '0;
    end else if (tempStb) begin
      if (sampleBin >= activeSet) begin
        activeSet <= sampleBin;
        streak    <= '0;
      end else if (sampleBin == candSet && streak != '0) begin
        if (streak != HYST_FULL) streak <= streak + 1'b1;
      end else begin
        candSet <= sampleBin;
        streak  <= HYST_W'(1);
      end
    end else if (streak == HYST_FULL && bankIdle) begin
      activeSet <= candSet;
      streak    <= '0;
    end
  end

  // One command per cycle, fixed priority.
  always_comb begin
    issue = '0;
    if (actReq && okVec.act)     issue.act = 1'b1;
    else if (rdReq && okVec.rd)  issue.rd  = 1'b1;
    else if (wrReq && okVec.wr)  issue.wr  = 1'b1;
    else if (preReq && okVec.pre) issue.pre = 1'b1;
  end

  // R9
  refresh_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refreshCode != '0) |=> (activeSet == WORST));

  // R6
  invalid_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tempStb && !tempOk) |=> (activeSet == WORST));

  // R8
  lower_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (activeSet < $past(activeSet))) |-> $past(bankIdle));
endmodule

// File: rtl/dat_timers.sv
module dat_timers
  import dat_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  cmd_t    issue,
  input  timing_t cur,
  output cmd_t    okVec,
  output logic    bankIdle
);
  localparam int NCNT = 3;
  localparam cnt_t SAT = '1;

  logic [NCNT-1:0] trigVec;
  cnt_t            elapsed [NCNT];
  logic            rowOpen;
  logic [CNT_W:0]  wrNeed;

  // 0: since activate, 1: since write, 2: since precharge
  assign trigVec = {issue.pre, issue.wr, issue.act};

  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      cnt_t el;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              el <= SAT;
        else if (trigVec[i])    el <= cnt_t'(1);
        else if (el != SAT)     el <= el + 1'b1;
      end
      assign elapsed[i] = el;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rowOpen <= 1'b0;
    else if (issue.act) rowOpen <= 1'b1;
    else if (issue.pre) rowOpen <= 1'b0;
  end

  assign wrNeed = {1'b0, cur.wr} + (CNT_W + 1)'(BURST_LEN);

  always_comb begin
    okVec.act = !rowOpen && (elapsed[2] >= cur.rp);
    okVec.rd  = rowOpen && (elapsed[0] >= cur.rcd);
    okVec.wr  = rowOpen && (elapsed[0] >= cur.rcd);
    okVec.pre = rowOpen && (elapsed[0] >= cur.ras) && ({1'b0, elapsed[1]} >= wrNeed);
  end

  assign bankIdle = okVec.act;

  // R5
  reopen_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue.act |=> !okVec.act);

  // R4
  wr_recovery_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue.wr |=> !okVec.pre);

  // R3
  closed_no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue.pre |=> (!okVec.rd && !okVec.wr && !okVec.pre));
endmodule

// File: rtl/dram_adaptive_timing.sv
module dram_adaptive_timing
  import dat_pkg::*;
#(
  parameter int NSETS     = 4,
  parameter int TEMP_W    = 8,
  parameter int REF_W     = 2,
  parameter int BIN_BASE  = 55,
  parameter int BIN_STEP  = 10,
  parameter int HYST      = 3,
  parameter int BURST_LEN = 4,
  parameter int RCD_WORST = 11,
  parameter int RAS_WORST = 28,
  parameter int WR_WORST  = 12,
  parameter int RP_WORST  = 11,
  parameter int RCD_CUT   = 17,
  parameter int RAS_CUT   = 37,
  parameter int WR_CUT    = 54,
  parameter int RP_CUT    = 35,
  localparam int SET_W    = $clog2(NSETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tempStb,
  input  logic              tempOk,
  input  logic [TEMP_W-1:0] tempC,
  input  logic [REF_W-1:0]  refreshCode,
  input  logic              actReq,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic              preReq,
  output logic              actOk,
  output logic              rdOk,
  output logic              wrOk,
  output logic              preOk,
  output logic [SET_W-1:0]  setIdx
);
  cmd_t    issue;
  cmd_t    okVec;
  timing_t cur;
  logic    bankIdle;

  dat_ctrl #(
    .NSETS(NSETS), .SET_W(SET_W), .TEMP_W(TEMP_W), .REF_W(REF_W),
    .BIN_BASE(BIN_BASE), .BIN_STEP(BIN_STEP), .HYST(HYST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tempStb(tempStb), .tempOk(tempOk), .tempC(tempC),
    .refreshCode(refreshCode), .actReq(actReq), .rdReq(rdReq), .wrReq(wrReq),
    .preReq(preReq), .okVec(okVec), .bankIdle(bankIdle), .issue(issue),
    .activeSet(setIdx)
  );

  dat_table #(
    .NSETS(NSETS), .SET_W(SET_W),
    .RCD_WORST(RCD_WORST), .RAS_WORST(RAS_WORST), .WR_WORST(WR_WORST), .RP_WORST(RP_WORST),
    .RCD_CUT(RCD_CUT), .RAS_CUT(RAS_CUT), .WR_CUT(WR_CUT), .RP_CUT(RP_CUT)
  ) u_table (
    .setIdx(setIdx), .cur(cur)
  );

  dat_timers #(
    .BURST_LEN(BURST_LEN)
  ) u_timers (
    .clk(clk), .rstN(rstN), .issue(issue), .cur(cur), .okVec(okVec), .bankIdle(bankIdle)
  );

  assign actOk = okVec.act;
  assign rdOk  = okVec.rd;
  assign wrOk  = okVec.wr;
  assign preOk = okVec.pre;
endmodule

// File: tb/sim_dram_adaptive_timing.sv
module sim_dram_adaptive_timing;
  localparam int HYST = 3;
  localparam int BL   = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       tempStb = 1'b0, tempOk = 1'b0;
  logic [7:0] tempC = '0;
  logic [1:0] refreshCode = '0;
  logic       actReq = 1'b0, rdReq = 1'b0, wrReq = 1'b0, preReq = 1'b0;
  logic       actOk, rdOk, wrOk, preOk;
  logic [1:0] setIdx;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  dram_adaptive_timing u0 (
    .clk(clk), .rstN(rstN), .tempStb(tempStb), .tempOk(tempOk), .tempC(tempC),
    .refreshCode(refreshCode), .actReq(actReq), .rdReq(rdReq), .wrReq(wrReq),
    .preReq(preReq), .actOk(actOk), .rdOk(rdOk), .wrOk(wrOk), .preOk(preOk),
    .setIdx(setIdx)
  );

  // kind 0 rcd, 1 ras, 2 wr, 3 rp
  function automatic int expT(int kind, int s);
    int w;
    int c;
    int cool;
    case (kind)
      0: begin w = 11; c = 17; end
      1: begin w = 28; c = 37; end
      2: begin w = 12; c = 54; end
      default: begin w = 11; c = 35; end
    endcase
    cool = (w * (100 - c) + 99) / 100;
    return cool + ((w - cool) * s + 2) / 3;
  endfunction

  function automatic int expBin(int t);
    if (t <= 55) return 0;
    if (t <= 65) return 1;
    if (t <= 75) return 2;
    return 3;
  endfunction

  task automatic checkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // kind 0 act, 1 rd, 2 wr, 3 pre; returns at the negedge after the issuing edge
  task automatic cmd(int kind);
    actReq = (kind == 0);
    rdReq  = (kind == 1);
    wrReq  = (kind == 2);
    preReq = (kind == 3);
    @(negedge clk);
    actReq = 1'b0; rdReq = 1'b0; wrReq = 1'b0; preReq = 1'b0;
  endtask

  task automatic strobe(int t, bit ok);
    tempStb = 1'b1;
    tempC   = 8'(t);
    tempOk  = ok;
    @(negedge clk);
    tempStb = 1'b0;
  endtask

  task automatic goDown(int t);
    repeat (HYST) strobe(t, 1'b1);
    @(negedge clk);
  endtask

  task automatic sweepSet(int s);
    int fr, fw, fp, fa;
    checkEq("R2 set index", int'(setIdx), s);
    fr = 0; fw = 0; fp = 0;
    cmd(0);
    for (int n = 1; n <= 60; n++) begin
      if (rdOk && fr == 0) fr = n;
      if (wrOk && fw == 0) fw = n;
      if (preOk && fp == 0) fp = n;
      @(negedge clk);
    end
    checkEq("R3 read after activate", fr, expT(0, s));
    checkEq("R3 write after activate", fw, expT(0, s));
    checkEq("R4 precharge after activate", fp, expT(1, s));
    fp = 0;
    cmd(2);
    for (int n = 1; n <= 60; n++) begin
      if (preOk && fp == 0) fp = n;
      @(negedge clk);
    end
    checkEq("R4 precharge after write", fp, BL + expT(2, s));
    fa = 0;
    cmd(3);
    checkEq("R3 read blocked after precharge", int'(rdOk), 0);
    for (int n = 1; n <= 60; n++) begin
      if (actOk && fa == 0) fa = n;
      @(negedge clk);
    end
    checkEq("R5 activate after precharge", fa, expT(3, s));
  endtask

  initial begin
    int fr, fp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    checkEq("R1 reset set", int'(setIdx), 3);
    checkEq("R1 reset actOk", int'(actOk), 1);
    checkEq("R1 reset rdOk", int'(rdOk), 0);
    checkEq("R1 reset wrOk", int'(wrOk), 0);
    checkEq("R1 reset preOk", int'(preOk), 0);

    sweepSet(3);

    // R8 hysteresis run length and restart
    repeat (HYST - 1) strobe(53, 1'b1);
    idle(3);
    checkEq("R8 short run keeps set", int'(setIdx), 3);
    strobe(83, 1'b1);
    repeat (HYST - 1) strobe(53, 1'b1);
    idle(3);
    checkEq("R8 restarted run keeps set", int'(setIdx), 3);
    strobe(53, 1'b1);
    checkEq("R8 commit not before next edge", int'(setIdx), 3);
    @(negedge clk);
    checkEq("R8 commit after full run", int'(setIdx), 0);

    sweepSet(0);
    strobe(63, 1'b1);
    checkEq("R7 immediate raise to 1", int'(setIdx), 1);
    sweepSet(1);
    strobe(73, 1'b1);
    checkEq("R7 immediate raise to 2", int'(setIdx), 2);
    sweepSet(2);

    // R10 raise in the middle of running intervals
    goDown(50);
    checkEq("R10 prepare fastest set", int'(setIdx), 0);
    cmd(0);
    @(negedge clk);
    strobe(90, 1'b1);
    checkEq("R7 over-range raise", int'(setIdx), 3);
    fr = 0; fp = 0;
    for (int n = 3; n <= 60; n++) begin
      if (rdOk && fr == 0) fr = n;
      if (preOk && fp == 0) fp = n;
      @(negedge clk);
    end
    checkEq("R10 read stretched to slow set", fr, expT(0, 3));
    checkEq("R10 precharge stretched to slow set", fp, expT(1, 3));
    cmd(3);
    idle(30);

    // R8 lowering held off by an open row and by the precharge interval
    cmd(0);
    repeat (HYST) strobe(53, 1'b1);
    idle(5);
    checkEq("R8 open row holds set", int'(setIdx), 3);
    idle(30);
    cmd(3);
    idle(4);
    checkEq("R8 precharge interval holds set", int'(setIdx), 3);
    idle(15);
    checkEq("R8 lower once idle", int'(setIdx), 0);

    // R11 priority: read wins over precharge
    cmd(0);
    idle(20);
    rdReq = 1'b1; preReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0; preReq = 1'b0;
    checkEq("R11 losing precharge ignored preOk", int'(preOk), 1);
    checkEq("R11 losing precharge ignored rdOk", int'(rdOk), 1);
    checkEq("R11 row still open actOk", int'(actOk), 0);
    cmd(3);
    idle(20);

    // R6 invalid reading
    strobe(40, 1'b0);
    checkEq("R6 invalid reading", int'(setIdx), 3);

    // R9 refresh interval override
    goDown(53);
    checkEq("R9 prepare", int'(setIdx), 0);
    refreshCode = 2'd2;
    @(negedge clk);
    checkEq("R9 forced worst", int'(setIdx), 3);
    repeat (HYST) strobe(53, 1'b1);
    idle(3);
    checkEq("R9 lowering blocked", int'(setIdx), 3);
    refreshCode = 2'd0;
    goDown(53);
    checkEq("R9 lowering after release", int'(setIdx), 0);

    // R6 bin sweep
    for (int t = 40; t <= 100; t++) begin
      strobe(85, 1'b1);
      goDown(t);
      checkEq($sformatf("R6 bin for %0d C", t), int'(setIdx), expBin(t));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule